// File: doc/BRIEF.md
# Vectored Interrupt Controller with Idle Wake

This block collects thirty-two level-sensitive interrupt sources and presents them to a processor on two active-low request lines: a fast request and a normal request. Source 0 feeds only the fast request. Source 1 is built inside the block as the OR of a group of system peripheral lines, so software has to poll those peripherals to learn which one fired. Sources 2 to 31 come straight from peripheral or external request lines, and each source number is the same as the identifier of the peripheral behind it.

Software uses a small register port. It sets and clears per-source enables, reads the pending sources and the lowest-numbered active normal source, and writes a general mask. When the mask is set, both request lines stay inactive, but a separate wake output still pulses the processor out of idle. The block runs on a clock that is never gated. An end-of-interrupt write exists for the software flow, but it clears nothing: a pending bit falls only when its source line falls.

Top module: `irq_vector_ctrl`

## Requirements
- R1: Source 0, when its line is high and its enable is set, drives `nfiq_n` low and never drives `nirq_n` low.
- R2: Source 1 is pending whenever any one bit of `sys_irq` is high and enable bit 1 is set.
- R3: Line `per_irq[k]`, for k from 2 to 31, maps to pending bit k.
- R4: A write to address 0 sets the enable bits that are 1 in `wdata`. A write to address 1 clears the enable bits that are 1 in `wdata`. Address 2 reads the enables. Address 4 reads the pending bits, and each pending bit is the source line ANDed with its enable.
- R5: Address 5 reads the lowest-numbered pending source among 1 to 31. When none of them is pending, it reads 32. It never reads 0.
- R6: With the mask clear, `nirq_n` goes low one clock after any of pending bits 1 to 31 becomes set, and `nfiq_n` goes low one clock after pending bit 0 becomes set. Each returns high one clock after its condition ends.
- R7: Address 3, bit 0, is the general mask. While it is set, `nirq_n` and `nfiq_n` stay high. A change to the mask reaches the outputs one clock after the register takes the write.
- R8: `wake` goes high one clock after any pending bit becomes set, whatever the mask holds, and it is high whenever either request output is low.
- R9: A write to address 6 (end of interrupt) changes no enable, pending bit or output. A pending bit clears only when its line falls.
- R10: After reset, all enables are 0, the mask is 0, both request outputs are high and `wake` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fiq_src | input | 1 | Source 0 request line |
| sys_irq | input | 4 | System peripheral lines, ORed into source 1 |
| per_irq | input | 30 | Request lines for sources 2 to 31 |
| we | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | 32 | Register write data |
| rdata | output | 32 | Register read data, combinational from `addr` |
| nfiq_n | output | 1 | Fast interrupt request, active low |
| nirq_n | output | 1 | Normal interrupt request, active low |
| wake | output | 1 | Wake request for an idle processor |

## Verification
The pending and current-source reads are combinational, so they are valid in the same cycle a line changes. `nfiq_n`, `nirq_n` and `wake` each go through one register, so they respond at the first rising edge after the stimulus. A mask write first lands in its own register, which delays its effect on the outputs by one more edge. The bench changes inputs on falling edges and reads results on the next falling edge. For the mask release it waits one extra cycle before it expects `nirq_n` to go low.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  typedef enum logic [2:0] {
    A_EN_SET  = 3'd0,
    A_EN_CLR  = 3'd1,
    A_EN_STAT = 3'd2,
    A_GMASK   = 3'd3,
    A_PEND    = 3'd4,
    A_CUR     = 3'd5,
    A_EOI     = 3'd6
  } irqc_addr_e;
endpackage

// File: rtl/irqc_src_map.sv
module irqc_src_map #(
  parameter int NUM_SRC = 32,
  parameter int NUM_SYS = 4
) (
  input  logic                 fiq_line,
  input  logic [NUM_SYS-1:0]   sys_lines,
  input  logic [NUM_SRC-3:0]   per_lines,
  output logic [NUM_SRC-1:0]   raw
);
  // slot 0 fast path, slot 1 system OR, remaining slots one line each
  assign raw[0] = fiq_line;
  assign raw[1] = |sys_lines;
  for (genvar g = 2; g < NUM_SRC; g++) begin : g_per
    assign raw[g] = per_lines[g-2];
  end
endmodule

// File: rtl/irqc_regs.sv
module irqc_regs
  import irqc_pkg::*;
#(
  parameter int NUM_SRC = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic [2:0]         addr,
  input  logic [NUM_SRC-1:0] wdata,
  output logic [NUM_SRC-1:0] enable_q,
  output logic               gmask_q
);
  logic [NUM_SRC-1:0] enable_d;
  logic               gmask_d;
  logic               upd_en;

  always_comb begin
    enable_d = enable_q;
    gmask_d  = gmask_q;
    if (we) begin
      case (irqc_addr_e'(addr))
        A_EN_SET: enable_d = enable_q | wdata;
        A_EN_CLR: enable_d = enable_q & ~wdata;
        A_GMASK:  gmask_d  = wdata[0];
        default:  ;
      endcase
    end
  end

  assign upd_en = we;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enable_q <= '0;
      gmask_q  <= 1'b0;
    end else if (upd_en) begin
      enable_q <= enable_d;
      gmask_q  <= gmask_d;
    end
  end

  // R9: end-of-interrupt write leaves the enables alone
  p_eoi_keeps_en_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == 3'(A_EOI)) |=> $stable(enable_q) && $stable(gmask_q));
endmodule

// File: rtl/irqc_priority.sv
module irqc_priority #(
  parameter int NUM_SRC = 32,
  localparam int SRC_W  = $clog2(NUM_SRC) + 1
) (
  input  logic [NUM_SRC-1:0] pending,
  output logic [SRC_W-1:0]   cur_src,
  output logic               any_irq
);
  localparam logic [SRC_W-1:0] NONE = SRC_W'(NUM_SRC);

  // scan from the top so the lowest-numbered request wins
  always_comb begin
    cur_src = NONE;
    for (int i = NUM_SRC - 1; i >= 1; i--) begin
      if (pending[i]) cur_src = SRC_W'(i);
    end
  end

  assign any_irq = |pending[NUM_SRC-1:1];
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import irqc_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int NUM_SYS = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fiq_src,
  input  logic [NUM_SYS-1:0] sys_irq,
  input  logic [NUM_SRC-1:2] per_irq,
  input  logic               we,
  input  logic [2:0]         addr,
  input  logic [NUM_SRC-1:0] wdata,
  output logic [NUM_SRC-1:0] rdata,
  output logic               nfiq_n,
  output logic               nirq_n,
  output logic               wake
);
  localparam int SRC_W = $clog2(NUM_SRC) + 1;
  localparam logic [SRC_W-1:0] NONE = SRC_W'(NUM_SRC);

  logic [NUM_SRC-1:0] raw, pending, enable_q;
  logic               gmask_q;
  logic [SRC_W-1:0]   cur_src;
  logic               any_irq;
  logic               nfiq_d, nirq_d, wake_d;

  irqc_src_map #(.NUM_SRC(NUM_SRC), .NUM_SYS(NUM_SYS)) u_map (
    .fiq_line (fiq_src),
    .sys_lines(sys_irq),
    .per_lines(per_irq),
    .raw      (raw)
  );

  irqc_regs #(.NUM_SRC(NUM_SRC)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (we),
    .addr    (addr),
    .wdata   (wdata),
    .enable_q(enable_q),
    .gmask_q (gmask_q)
  );

  assign pending = raw & enable_q;

  irqc_priority #(.NUM_SRC(NUM_SRC)) u_prio (
    .pending(pending),
    .cur_src(cur_src),
    .any_irq(any_irq)
  );

  always_comb begin
    nfiq_d = ~(pending[0] & ~gmask_q);
    nirq_d = ~(any_irq & ~gmask_q);
    wake_d = |pending;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nfiq_n <= 1'b1;
      nirq_n <= 1'b1;
      wake   <= 1'b0;
    end else begin
      nfiq_n <= nfiq_d;
      nirq_n <= nirq_d;
      wake   <= wake_d;
    end
  end

  always_comb begin
    case (irqc_addr_e'(addr))
      A_EN_STAT: rdata = enable_q;
      A_GMASK:   rdata = NUM_SRC'(gmask_q);
      A_PEND:    rdata = pending;
      A_CUR:     rdata = NUM_SRC'(cur_src);
      default:   rdata = '0;
    endcase
  end

  // R1: a normal request never comes from source 0 alone
  p_fiq_only_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !nirq_n |-> $past(|(raw[NUM_SRC-1:1] & enable_q[NUM_SRC-1:1])));
  // R5: the current source is never 0, and it is NONE exactly when no normal source is pending
  p_cur_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cur_src != '0 && ((cur_src == NONE) == !(|pending[NUM_SRC-1:1])));
  // R7: a set mask holds both request lines high on the next edge
  p_mask_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
    gmask_q |=> nirq_n && nfiq_n);
  // R8: wake is high whenever a request output is low
  p_wake_cover_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!nirq_n || !nfiq_n) |-> wake);
endmodule

// File: tb/irq_vector_ctrl_tb.sv
module irq_vector_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N = 32;

  logic          clk, rst_n, fiq_src, we;
  logic [3:0]    sys_irq;
  logic [N-1:2]  per_irq;
  logic [2:0]    addr;
  logic [N-1:0]  wdata, rdata;
  logic          nfiq_n, nirq_n, wake;

  int n_checks = 0;
  int n_fails  = 0;

  irq_vector_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .fiq_src(fiq_src), .sys_irq(sys_irq),
    .per_irq(per_irq), .we(we), .addr(addr), .wdata(wdata),
    .rdata(rdata), .nfiq_n(nfiq_n), .nirq_n(nirq_n), .wake(wake)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    we = 1'b1; addr = a; wdata = d;
    @(posedge clk); @(negedge clk);
    we = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    check("R10 nfiq", 32'(nfiq_n), 32'd1);
    check("R10 nirq", 32'(nirq_n), 32'd1);
    check("R10 wake", 32'(wake), 32'd0);
    rd(3'd2, v); check("R10 enables", v, 32'h0);
    rd(3'd3, v); check("R10 mask", v, 32'h0);
    rd(3'd5, v); check("R5 none", v, 32'd32);
  endtask

  task automatic t_enables;
    logic [31:0] v;
    wr(3'd0, 32'hFFFF_FFFF);
    rd(3'd2, v); check("R4 set", v, 32'hFFFF_FFFF);
    wr(3'd1, 32'h0000_0020);
    rd(3'd2, v); check("R4 clear", v, 32'hFFFF_FFDF);
  endtask

  task automatic t_fiq_only;
    logic [31:0] v;
    fiq_src = 1'b1;
    rd(3'd4, v); check("R1 pend", v, 32'h1);
    rd(3'd5, v); check("R5 fiq not current", v, 32'd32);
    @(negedge clk);
    check("R6 nfiq low", 32'(nfiq_n), 32'd0);
    check("R1 nirq high", 32'(nirq_n), 32'd1);
    check("R8 wake", 32'(wake), 32'd1);
    fiq_src = 1'b0;
    @(negedge clk);
    check("R6 nfiq release", 32'(nfiq_n), 32'd1);
    check("R8 wake release", 32'(wake), 32'd0);
  endtask

  task automatic t_sys_or;
    logic [31:0] v;
    for (int i = 0; i < 4; i++) begin
      sys_irq = 4'(1 << i);
      @(negedge clk);
      rd(3'd4, v); check("R2 pend", v, 32'h2);
      rd(3'd5, v); check("R2 cur", v, 32'd1);
      check("R2 nirq", 32'(nirq_n), 32'd0);
      sys_irq = '0;
      @(negedge clk);
      check("R6 nirq release", 32'(nirq_n), 32'd1);
    end
  endtask

  task automatic t_priority;
    logic [31:0] v;
    per_irq[30] = 1'b1; per_irq[12] = 1'b1; per_irq[7] = 1'b1; per_irq[5] = 1'b1;
    rd(3'd4, v); check("R3 R4 pend gated", v, 32'h4000_1080);
    rd(3'd5, v); check("R5 lowest", v, 32'd7);
    @(negedge clk);
    check("R6 nirq", 32'(nirq_n), 32'd0);
    per_irq[7] = 1'b0;
    rd(3'd5, v); check("R5 next", v, 32'd12);
    sys_irq[2] = 1'b1;
    rd(3'd5, v); check("R5 source1 wins", v, 32'd1);
    sys_irq = '0; per_irq = '0;
    @(negedge clk);
    check("R6 idle", 32'(nirq_n), 32'd1);
  endtask

  task automatic t_mask_wake;
    logic [31:0] v;
    wr(3'd3, 32'h1);
    rd(3'd3, v); check("R7 mask read", v, 32'h1);
    per_irq[9] = 1'b1; fiq_src = 1'b1;
    @(negedge clk);
    check("R7 nirq held", 32'(nirq_n), 32'd1);
    check("R7 nfiq held", 32'(nfiq_n), 32'd1);
    check("R8 wake masked", 32'(wake), 32'd1);
    wr(3'd3, 32'h0);
    check("R7 one edge lag", 32'(nirq_n), 32'd1);
    @(negedge clk);
    check("R7 nirq after unmask", 32'(nirq_n), 32'd0);
    check("R7 nfiq after unmask", 32'(nfiq_n), 32'd0);
    per_irq = '0; fiq_src = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_eoi;
    logic [31:0] v;
    per_irq[20] = 1'b1;
    @(negedge clk);
    check("R6 nirq src20", 32'(nirq_n), 32'd0);
    wr(3'd6, 32'd20);
    rd(3'd4, v); check("R9 pend kept", v, 32'h0010_0000);
    rd(3'd2, v); check("R9 enables kept", v, 32'hFFFF_FFDF);
    check("R9 nirq kept", 32'(nirq_n), 32'd0);
    per_irq[20] = 1'b0;
    @(negedge clk);
    check("R9 line drop clears", 32'(nirq_n), 32'd1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++; n_fails++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; fiq_src = 1'b0; sys_irq = '0; per_irq = '0;
    we = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_enables();
    t_fiq_only();
    t_sys_or();
    t_priority();
    t_mask_wake();
    t_eoi();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end
endmodule